// File: doc/BRIEF.md
# Dual-Address I2C Slave Address Matcher

This block listens on the two lines of an I2C bus as a slave. It brings both lines into the system clock domain and finds start and stop conditions. After each start it collects the first byte, then compares that byte's seven address bits with two address registers that software can program. The low bit of each address register joins with the low bit of the other to form a two-bit format code. That code enables the first compare, the second compare, both, or neither. The "neither" case is a plain synchronous serial format with no addressing.

Software sees four register slots. Slot 0 is shared. While the interface enable bit is clear, slot 0 reads and writes the primary address register. While the enable bit is set, slot 0 reaches an 8-bit mode register and the primary address cannot be changed. Slot 1 holds the secondary address. Slot 2 holds the enable bit. The outputs are an addressed flag, a one-hot pair that says which address matched, and the direction bit of the last captured address byte.

Top module: `i2c_dual_addr_match`

## Requirements
- R1: After reset, the primary, secondary, mode and enable registers are all zero. The addressed flag, both hit flags and the direction output are 0.
- R2: The register slots are: offset 0 the shared slot, offset 1 the secondary address, offset 2 the control register with the enable in bit 0, offset 3 reserved. Offset 3 reads 0 and ignores writes. Each slot reads back what was last written to it, and the control register returns only bit 0.
- R3: While enable=0, offset 0 reaches the primary address register. While enable=1, offset 0 reaches the mode register, and writes there leave the primary address unchanged.
- R4: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Either one clears the addressed and hit flags. A start, including a repeated start in the middle of a byte, restarts first-byte capture from bit 7.
- R5: The first byte after a start is sampled on rising SCL edges, MSB first. After the eighth bit, byte bits 7:1 are compared with bits 7:1 of each enabled address register, and the direction output takes byte bit 0. Later SCL edges leave all outputs unchanged until the next start or stop.
- R6: FS is bit 0 of the primary register and FSX is bit 0 of the secondary register. The code {FS,FSX} selects the compares: 00 both addresses, 01 primary only, 10 secondary only, 11 neither (synchronous serial format).
- R7: When both addresses match, hit_pri_o=1 and hit_sec_o=0. addressed_o is the OR of the two hit flags.
- R8: No address is recognised while enable=0.
- R9: With the default two synchronizer stages, a line change made before rising clock edge k shows on the outputs after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_ofs | input | 2 | Register slot offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_ofs |
| addressed_o | output | 1 | Block is the addressed slave |
| hit_pri_o | output | 1 | Primary address matched |
| hit_sec_o | output | 1 | Secondary address matched |
| rw_o | output | 1 | Direction bit of the last captured first byte |

## Verification
Bus-driven results appear after the third rising clock edge that follows a line change: two edges pass through the synchronizers and one updates the flags. The reference model in the bench delays the applied line values through a queue by the same three edges. Register writes are visible on reg_rdata one edge later, and reads are combinational. The bench compares every output at each falling clock edge, so every cycle is checked against the due values. A dedicated check also samples the flags after the second and the third edge following the last address bit.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

   typedef enum logic [1:0] {
      OFS_SHARED = 2'd0,
      OFS_SECOND = 2'd1,
      OFS_CTRL   = 2'd2,
      OFS_RSVD   = 2'd3
   } reg_ofs_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
      logic sda;
   } line_ev_t;

endpackage

// File: rtl/iam_sync.sv
module iam_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("iam_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/iam_line_mon.sv
module iam_line_mon
   import i2c_am_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output line_ev_t ev_o
);
   localparam int NLINES = 2;
   localparam int L_SCL  = 1;
   localparam int L_SDA  = 0;

   logic [NLINES-1:0] raw, syn, prv;
   assign raw = {scl_i, sda_i};

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      iam_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (raw[i]),
         .q     (syn[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv <= '1;
      else        prv <= syn;
   end

   logic scl_hi;
   assign scl_hi        = syn[L_SCL] & prv[L_SCL];
   assign ev_o.start    = scl_hi &  prv[L_SDA] & ~syn[L_SDA];
   assign ev_o.stop     = scl_hi & ~prv[L_SDA] &  syn[L_SDA];
   assign ev_o.scl_rise = syn[L_SCL] & ~prv[L_SCL];
   assign ev_o.sda      = syn[L_SDA];

   a_r4_not_both_events: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_o.start && ev_o.stop));
endmodule

// File: rtl/iam_regs.sv
module iam_regs
   import i2c_am_pkg::*;
#(
   parameter int REG_W = 8,
   parameter int OFS_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] rdata_o,
   output logic [REG_W-1:0] pri_o,
   output logic [REG_W-1:0] sec_o,
   output logic             en_o
);
   if (OFS_W != 2) begin : g_bad_ofs
      $error("iam_regs: slot decode needs a 2-bit offset");
   end
   if (REG_W < 2) begin : g_bad_w
      $error("iam_regs: register needs address and format bits");
   end

   reg_ofs_e         sel;
   logic [REG_W-1:0] pri_q, sec_q, mode_q;
   logic             en_q;

   assign sel = reg_ofs_e'(ofs_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_q  <= '0;
         sec_q  <= '0;
         mode_q <= '0;
         en_q   <= 1'b0;
      end else if (we_i) begin
         unique case (sel)
            OFS_SHARED: begin
               if (en_q) mode_q <= wdata_i;
               else      pri_q  <= wdata_i;
            end
            OFS_SECOND: sec_q <= wdata_i;
            OFS_CTRL:   en_q  <= wdata_i[0];
            default:    ;
         endcase
      end
   end

   always_comb begin
      unique case (sel)
         OFS_SHARED: rdata_o = en_q ? mode_q : pri_q;
         OFS_SECOND: rdata_o = sec_q;
         OFS_CTRL:   rdata_o = {{(REG_W-1){1'b0}}, en_q};
         default:    rdata_o = '0;
      endcase
   end

   assign pri_o = pri_q;
   assign sec_o = sec_q;
   assign en_o  = en_q;

   a_r3_shared_writes_primary: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && sel == OFS_SHARED && !en_q) |=> (pri_o == $past(wdata_i)));
   a_r3_primary_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && sel == OFS_SHARED && en_q) |=> $stable(pri_o));
   a_r2_rsvd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OFS_RSVD) |-> (rdata_o == '0));
endmodule

// File: rtl/iam_capture.sv
module iam_capture
   import i2c_am_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  line_ev_t          ev_i,
   input  logic [ADDR_W-1:0] pri_addr_i,
   input  logic [ADDR_W-1:0] sec_addr_i,
   input  logic              fs_i,
   input  logic              fsx_i,
   input  logic              en_i,
   output logic              addressed_o,
   output logic              hit_pri_o,
   output logic              hit_sec_o,
   output logic              rw_o
);
   localparam int BYTE_W = ADDR_W + 1;
   localparam int CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   logic              busy;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] shreg;
   logic              last_bit, hit_p, hit_s;

   // Address bits are all in shreg when the direction bit arrives.
   assign last_bit = ev_i.scl_rise && busy && (cnt == LAST);
   assign hit_p    = en_i && !fs_i  && (shreg == pri_addr_i);
   assign hit_s    = en_i && !fsx_i && (shreg == sec_addr_i) && !hit_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         cnt         <= '0;
         shreg       <= '0;
         addressed_o <= 1'b0;
         hit_pri_o   <= 1'b0;
         hit_sec_o   <= 1'b0;
         rw_o        <= 1'b0;
      end else if (ev_i.start) begin
         busy        <= 1'b1;
         cnt         <= '0;
         addressed_o <= 1'b0;
         hit_pri_o   <= 1'b0;
         hit_sec_o   <= 1'b0;
      end else if (ev_i.stop) begin
         busy        <= 1'b0;
         addressed_o <= 1'b0;
         hit_pri_o   <= 1'b0;
         hit_sec_o   <= 1'b0;
      end else if (last_bit) begin
         busy        <= 1'b0;
         rw_o        <= ev_i.sda;
         addressed_o <= hit_p | hit_s;
         hit_pri_o   <= hit_p;
         hit_sec_o   <= hit_s;
      end else if (ev_i.scl_rise && busy) begin
         cnt   <= cnt + 1'b1;
         shreg <= {shreg[ADDR_W-2:0], ev_i.sda};
      end
   end

   a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i.start |=> !addressed_o);
   a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i.stop |=> !addressed_o);
   a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (addressed_o && !ev_i.start && !ev_i.stop) |=> addressed_o);
   a_r7_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_pri_o, hit_sec_o}));
   a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addressed_o) |-> $past(en_i));
   a_r6_no_match_sync_fmt: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addressed_o) |-> !$past(fs_i && fsx_i));
endmodule

// File: rtl/i2c_dual_addr_match.sv
module i2c_dual_addr_match
   import i2c_am_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter int OFS_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              reg_we,
   input  logic [OFS_W-1:0]  reg_ofs,
   input  logic [ADDR_W:0]   reg_wdata,
   output logic [ADDR_W:0]   reg_rdata,
   output logic              addressed_o,
   output logic              hit_pri_o,
   output logic              hit_sec_o,
   output logic              rw_o
);
   localparam int REG_W = ADDR_W + 1;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("i2c_dual_addr_match: ADDR_W too small");
   end

   line_ev_t         ev;
   logic [REG_W-1:0] pri, sec;
   logic             en;

   iam_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev_o  (ev)
   );

   iam_regs #(.REG_W(REG_W), .OFS_W(OFS_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (reg_we),
      .ofs_i   (reg_ofs),
      .wdata_i (reg_wdata),
      .rdata_o (reg_rdata),
      .pri_o   (pri),
      .sec_o   (sec),
      .en_o    (en)
   );

   iam_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_i        (ev),
      .pri_addr_i  (pri[REG_W-1:1]),
      .sec_addr_i  (sec[REG_W-1:1]),
      .fs_i        (pri[0]),
      .fsx_i       (sec[0]),
      .en_i        (en),
      .addressed_o (addressed_o),
      .hit_pri_o   (hit_pri_o),
      .hit_sec_o   (hit_sec_o),
      .rw_o        (rw_o)
   );

   a_r7_addressed_is_or: assert property (@(posedge clk) disable iff (!rst_n)
      addressed_o == (hit_pri_o | hit_sec_o));
endmodule

// File: tb/i2c_dual_addr_match_bench.sv
module i2c_dual_addr_match_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 3;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1, sda = 1'b1;
   logic       reg_we = 1'b0;
   logic [1:0] reg_ofs = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       addressed, hit_pri, hit_sec, rw;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_dual_addr_match u_i2c_dual_addr_match (
      .clk (clk), .rst_n (rst_n), .scl_i (scl), .sda_i (sda),
      .reg_we (reg_we), .reg_ofs (reg_ofs), .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata), .addressed_o (addressed),
      .hit_pri_o (hit_pri), .hit_sec_o (hit_sec), .rw_o (rw)
   );

   task automatic check(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [1:0] lq[$];
   logic [7:0] m_pri, m_sec, m_mode;
   bit m_en, m_busy, m_addr, m_hp, m_hs, m_rw;
   int m_nb;
   logic [7:0] m_byte;

   always @(posedge clk) begin
      if (!rst_n) begin
         lq = '{2'b11, 2'b11, 2'b11};
         m_pri = 0; m_sec = 0; m_mode = 0; m_en = 0;
         m_busy = 0; m_addr = 0; m_hp = 0; m_hs = 0; m_rw = 0; m_nb = 0; m_byte = 0;
      end else begin
         logic [1:0] cur, prv;
         lq.push_back({scl, sda});
         cur = lq[1];
         prv = lq[0];
         void'(lq.pop_front());
         if (prv[1] && cur[1] && prv[0] && !cur[0]) begin
            m_busy = 1; m_nb = 0; m_addr = 0; m_hp = 0; m_hs = 0;
         end else if (prv[1] && cur[1] && !prv[0] && cur[0]) begin
            m_busy = 0; m_addr = 0; m_hp = 0; m_hs = 0;
         end else if (!prv[1] && cur[1] && m_busy) begin
            m_byte = {m_byte[6:0], cur[0]};
            m_nb++;
            if (m_nb == 8) begin
               m_busy = 0;
               m_rw = cur[0];
               m_hp = m_en && !m_pri[0] && (m_byte[7:1] == m_pri[7:1]);
               m_hs = m_en && !m_sec[0] && (m_byte[7:1] == m_sec[7:1]) && !m_hp;
               m_addr = m_hp || m_hs;
            end
         end
         if (reg_we) begin
            case (reg_ofs)
               2'd0: if (m_en) m_mode = reg_wdata; else m_pri = reg_wdata;
               2'd1: m_sec = reg_wdata;
               2'd2: m_en = reg_wdata[0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [7:0] m_rdata(input logic [1:0] ofs);
      case (ofs)
         2'd0: return m_en ? m_mode : m_pri;
         2'd1: return m_sec;
         2'd2: return {7'd0, m_en};
         default: return 8'd0;
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R9", "addressed vs model", addressed, m_addr);
         check("R7", "hit_pri vs model", hit_pri, m_hp);
         check("R6", "hit_sec vs model", hit_sec, m_hs);
         check("R5", "rw vs model", rw, m_rw);
         check("R2", "rdata vs model", reg_rdata, m_rdata(reg_ofs));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] ofs, input logic [7:0] d);
      reg_we = 1; reg_ofs = ofs; reg_wdata = d;
      idle(1);
      reg_we = 0;
   endtask

   task automatic rd_check(input string req, input logic [1:0] ofs, input logic [7:0] exp);
      reg_ofs = ofs;
      #(CLK_PERIOD/4);
      check(req, "register read", reg_rdata, exp);
      idle(1);
   endtask

   task automatic bus_bit(input logic b);
      sda = b; idle(HOLD);
      scl = 1; idle(HOLD);
      scl = 0; idle(HOLD);
   endtask

   task automatic bus_start;
      sda = 1; idle(HOLD);
      scl = 1; idle(HOLD);
      sda = 0; idle(HOLD);
      scl = 0; idle(HOLD);
   endtask

   task automatic bus_stop;
      sda = 0; idle(HOLD);
      scl = 1; idle(HOLD);
      sda = 1; idle(HOLD);
   endtask

   task automatic bus_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) bus_bit(b[i]);
   endtask

   task automatic expect_out(input string req, input bit a, input bit p, input bit s, input bit r);
      check(req, "addressed", addressed, a);
      check(req, "hit_pri", hit_pri, p);
      check(req, "hit_sec", hit_sec, s);
      check(req, "rw", rw, r);
   endtask

   task automatic frame(input logic [7:0] b);
      bus_start;
      bus_byte(b);
      idle(2);
   endtask

   // ---------------- scenario ----------------
   initial begin
      idle(3);
      rst_n = 1;
      idle(2);
      // R1: reset state
      expect_out("R1", 0, 0, 0, 0);
      rd_check("R1", 2'd0, 8'h00);
      rd_check("R1", 2'd1, 8'h00);
      rd_check("R1", 2'd2, 8'h00);

      // R2: slot map and read-back; reserved slot reads zero
      wr(2'd0, 8'h54);
      wr(2'd1, 8'h66);
      wr(2'd3, 8'hFF);
      rd_check("R2", 2'd0, 8'h54);
      rd_check("R2", 2'd1, 8'h66);
      rd_check("R2", 2'd3, 8'h00);
      wr(2'd2, 8'hFF);
      rd_check("R2", 2'd2, 8'h01);

      // R3: shared slot reaches the mode register while enabled
      wr(2'd0, 8'hA5);
      rd_check("R3", 2'd0, 8'hA5);
      wr(2'd2, 8'h00);
      rd_check("R3", 2'd0, 8'h54);
      wr(2'd2, 8'h01);

      // R5: primary address match, read direction
      frame(8'h55);
      expect_out("R5", 1, 1, 0, 1);
      bus_byte(8'h00);                  // later bits leave outputs alone
      expect_out("R5", 1, 1, 0, 1);
      bus_stop; idle(4);
      expect_out("R4", 0, 0, 0, 1);     // stop clears flags

      // R6: code 00, secondary match, write direction
      frame(8'h66);
      expect_out("R6", 1, 0, 1, 0);
      bus_stop;
      frame(8'h11);                     // no match, rw taken
      expect_out("R5", 0, 0, 0, 1);
      bus_stop;

      // R6: code 01 -> primary only
      wr(2'd1, 8'h67);
      frame(8'h66);
      expect_out("R6", 0, 0, 0, 0);
      bus_stop;
      frame(8'h54);
      expect_out("R6", 1, 1, 0, 0);
      bus_stop;

      // R6: code 10 -> secondary only
      wr(2'd2, 8'h00); wr(2'd0, 8'h55); wr(2'd1, 8'h66); wr(2'd2, 8'h01);
      frame(8'h54);
      expect_out("R6", 0, 0, 0, 0);
      bus_stop;
      frame(8'h67);
      expect_out("R6", 1, 0, 1, 1);
      bus_stop;

      // R6: code 11 -> synchronous serial, nothing recognised
      wr(2'd1, 8'h67);
      frame(8'h54);
      expect_out("R6", 0, 0, 0, 0);
      bus_stop;
      frame(8'h66);
      expect_out("R6", 0, 0, 0, 0);
      bus_stop;

      // R7: both match, primary wins
      wr(2'd2, 8'h00); wr(2'd0, 8'h54); wr(2'd1, 8'h54); wr(2'd2, 8'h01);
      frame(8'h54);
      expect_out("R7", 1, 1, 0, 0);
      bus_stop;

      // R8: disabled -> no recognition
      wr(2'd2, 8'h00);
      frame(8'h54);
      expect_out("R8", 0, 0, 0, 0);
      bus_stop;
      wr(2'd2, 8'h01);

      // R4: repeated start mid-byte restarts capture
      bus_start;
      bus_bit(1); bus_bit(1); bus_bit(0); bus_bit(1);
      scl = 0; bus_start;
      bus_byte(8'h55);
      idle(2);
      expect_out("R4", 1, 1, 0, 1);
      bus_start;                        // repeated start clears flag
      expect_out("R4", 0, 0, 0, 1);
      bus_byte(8'h54);
      idle(2);
      expect_out("R4", 1, 1, 0, 0);
      bus_stop;

      // R9: latency of three edges after the last address bit
      bus_start;
      for (int i = 7; i >= 1; i--) bus_bit(i[0] ? 1'b0 : 1'b1); // 0x54 >> 1 pattern
      sda = 0; idle(HOLD);
      scl = 1;
      idle(2);
      check("R9", "addressed after 2 edges", addressed, 0);
      idle(1);
      check("R9", "addressed after 3 edges", addressed, 1);
      scl = 0; idle(HOLD);
      bus_stop; idle(4);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule